// File: doc/BRIEF.md
# Predicate Mask Fetch Sequencer

This block produces the source and destination element masks that a predicated vector instruction needs before it can issue. A request carries a predicate mode, two 3-bit selector codes (one for each mask) and the vector length. The block answers with two 64-bit masks, which stay valid until the consumer takes them.

In integer mode each selector names one of a few integer registers. The block reads that register through a read port whose data returns one clock after the enable. It then passes the value through, inverts it, or turns its low six bits into a one-hot value. One selector code means "every element enabled" and needs no read at all.

In condition-register mode each selector picks one bit of a 4-bit condition field, possibly inverted. The block reads field 0 to field VL-1 one at a time and gathers one bit per element. Mask bits at VL and above are zero. In any other mode both masks are all ones and no read takes place. The source mask is always built before the destination mask.

Top module: `pmask_seq`

## Requirements
- R1: After reset, req_ready is 1, mask_valid is 0 and both masks are 0.
- R2: A request with req_mode 2'b00 or 2'b11 returns both masks as all ones and issues no integer or condition-field read.
- R3: In integer mode (req_mode 2'b01) the selector codes decode as follows: 0 = all ones; 2 = r3; 3 = ~r3; 4 = r10; 5 = ~r10; 6 = r30; 7 = ~r30. Code 0 issues no read, and the mask is all ones whatever r0 holds.
- R4: Integer selector code 1 yields a mask with exactly one bit set, at position r3[5:0].
- R5: An integer read takes its data one clock after int_rd_en. Each selector other than code 0 issues exactly one read, the source read comes before the destination read, and no two reads fall in consecutive cycles.
- R6: In condition-register mode (req_mode 2'b10), mask bit i = field_i[code[2:1]] XOR code[0]. So codes 0/1 use bit 0 set/clear, 2/3 use bit 1, 4/5 use bit 2 and 6/7 use bit 3.
- R7: Condition-register mode reads field i for element i, for i from 0 to VL-1, once per mask, which gives 2*VL reads. Mask bits at VL and above are 0. VL = 0 gives two zero masks and no reads.
- R8: req_ready is 1 only when the block is idle. While mask_valid is 1 and mask_ready is 0, mask_valid stays 1 and both masks stay stable.
- R9: After the output handshake completes, both masks keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_mode | input | 2 | Predicate mode: 01 integer, 10 condition register, else none |
| req_src_sel | input | 3 | Source mask selector code |
| req_dst_sel | input | 3 | Destination mask selector code |
| req_vl | input | 7 | Vector length, 0 to 64 |
| int_rd_en | output | 1 | Integer register read enable |
| int_rd_idx | output | 5 | Integer register number to read |
| int_rd_data | input | 64 | Integer read data, one clock after enable |
| cr_rd_en | output | 1 | Condition field read enable |
| cr_rd_idx | output | 6 | Condition field number (element index) |
| cr_rd_data | input | 4 | Condition field data, one clock after enable |
| mask_valid | output | 1 | Masks complete and offered |
| mask_ready | input | 1 | Consumer takes the masks |
| src_mask | output | 64 | Source element mask |
| dst_mask | output | 64 | Destination element mask |

## Verification
The hardest case to reach is the end of the condition-register walk at the full length of 64. There the element counter must stop at its top value and not wrap. Bits beyond a short length must stay zero even though the field data presented there is non-zero. The stimulus runs every pair of source and destination codes at lengths 0, 1, 37 and 64, against two complementary field patterns. A read-response model in the bench counts the reads for each request, so a missing or extra read shows up even when the mask happens to match.

// File: rtl/pmask_pkg.sv
// Shared encodings for the predicate mask sequencer.
// Assumes 2-bit mode codes and 3-bit selector codes as listed in the brief.
package pmask_pkg;
    localparam logic [1:0] MODE_INT = 2'b01;
    localparam logic [1:0] MODE_CR  = 2'b10;

    localparam logic [2:0] ISEL_ALL   = 3'd0;
    localparam logic [2:0] ISEL_UNARY = 3'd1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INT_RD,
        S_INT_CAP,
        S_CR_RD,
        S_CR_CAP,
        S_DONE
    } seq_state_t;
endpackage

// File: rtl/pmask_int_dec.sv
// Integer selector decoder: maps a 3-bit code to a register number,
// an invert flag, a unary flag and an all-ones flag (no read needed).
// Assumes codes 2..7 pair r3, r10, r30 as plain/inverted.
module pmask_int_dec #(
    parameter int REG_W = 5
) (
    input  logic [2:0]       sel,
    output logic [REG_W-1:0] reg_num,
    output logic             invert,
    output logic             unary,
    output logic             all_ones
);
    import pmask_pkg::*;

    // Purpose: table lookup of the selector code.
    always_comb begin
        invert   = sel[0] & (sel[2:1] != 2'b00);
        unary    = (sel == ISEL_UNARY);
        all_ones = (sel == ISEL_ALL);
        unique case (sel[2:1])
            2'b00:   reg_num = all_ones ? '0 : REG_W'(3);
            2'b01:   reg_num = REG_W'(3);
            2'b10:   reg_num = REG_W'(10);
            default: reg_num = REG_W'(30);
        endcase
    end
endmodule

// File: rtl/pmask_cr_dec.sv
// Condition selector decoder: upper code bits pick the field bit,
// lowest code bit inverts it. Assumes CR_W is a power of two >= 4.
module pmask_cr_dec #(
    parameter int CR_W = 4,
    localparam int BI_W = $clog2(CR_W)
) (
    input  logic [2:0]      sel,
    output logic [BI_W-1:0] bit_idx,
    output logic            invert
);
    // Purpose: split selector into bit index and polarity.
    always_comb begin
        bit_idx = BI_W'(sel[2:1]);
        invert  = sel[0];
    end
endmodule

// File: rtl/pmask_int_shape.sv
// Shapes a raw integer register value into a mask: pass, invert,
// or one-hot of its low log2(XLEN) bits. Unary takes priority.
module pmask_int_shape #(
    parameter int XLEN = 64,
    localparam int SH_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] raw,
    input  logic            invert,
    input  logic            unary,
    output logic [XLEN-1:0] mask
);
    // Purpose: select the transform for the captured register value.
    always_comb begin
        if (unary)
            mask = XLEN'(1) << raw[SH_W-1:0];
        else if (invert)
            mask = ~raw;
        else
            mask = raw;
    end
endmodule

// File: rtl/pmask_seq.sv
// Predicate mask sequencer top. Accepts a request, builds the source
// mask then the destination mask from integer reads or a per-element
// condition field walk, and offers both masks until accepted.
// Assumes read data returns one clock after enable, and req_vl <= XLEN.
module pmask_seq #(
    parameter int XLEN  = 64,
    parameter int CR_W  = 4,
    parameter int REG_W = 5,
    localparam int VL_W = $clog2(XLEN + 1),
    localparam int EL_W = $clog2(XLEN),
    localparam int BI_W = $clog2(CR_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_mode,
    input  logic [2:0]       req_src_sel,
    input  logic [2:0]       req_dst_sel,
    input  logic [VL_W-1:0]  req_vl,
    output logic             int_rd_en,
    output logic [REG_W-1:0] int_rd_idx,
    input  logic [XLEN-1:0]  int_rd_data,
    output logic             cr_rd_en,
    output logic [EL_W-1:0]  cr_rd_idx,
    input  logic [CR_W-1:0]  cr_rd_data,
    output logic             mask_valid,
    input  logic             mask_ready,
    output logic [XLEN-1:0]  src_mask,
    output logic [XLEN-1:0]  dst_mask
);
    import pmask_pkg::*;

    seq_state_t       st;
    logic [2:0]       src_sel_q, dst_sel_q, cur_sel;
    logic [VL_W-1:0]  vl_q;
    logic [EL_W-1:0]  elem;
    logic             phase;
    logic [XLEN-1:0]  srcm, dstm;

    logic [REG_W-1:0] d_reg;
    logic             d_inv, d_unary, d_all;
    logic [BI_W-1:0]  c_bit;
    logic             c_inv;
    logic [XLEN-1:0]  shaped;
    logic             cr_bit, last_elem;

    pmask_int_dec #(.REG_W(REG_W)) u_idec (
        .sel(cur_sel), .reg_num(d_reg), .invert(d_inv),
        .unary(d_unary), .all_ones(d_all)
    );

    pmask_cr_dec #(.CR_W(CR_W)) u_cdec (
        .sel(cur_sel), .bit_idx(c_bit), .invert(c_inv)
    );

    pmask_int_shape #(.XLEN(XLEN)) u_shape (
        .raw(int_rd_data), .invert(d_inv), .unary(d_unary), .mask(shaped)
    );

    // Purpose: selector of the mask currently being built.
    always_comb cur_sel = phase ? dst_sel_q : src_sel_q;

    // Purpose: per-element bit and end-of-walk detection.
    always_comb begin
        cr_bit    = cr_rd_data[c_bit] ^ c_inv;
        last_elem = (VL_W'(elem) == vl_q - VL_W'(1));
    end

    // Purpose: drive handshakes, read ports and mask outputs.
    always_comb begin
        req_ready  = (st == S_IDLE);
        mask_valid = (st == S_DONE);
        int_rd_en  = (st == S_INT_RD) && !d_all;
        int_rd_idx = int_rd_en ? d_reg : '0;
        cr_rd_en   = (st == S_CR_RD);
        cr_rd_idx  = cr_rd_en ? elem : '0;
        src_mask   = srcm;
        dst_mask   = dstm;
    end

    // Purpose: sequencing FSM and mask accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            src_sel_q <= '0;
            dst_sel_q <= '0;
            vl_q      <= '0;
            elem      <= '0;
            phase     <= 1'b0;
            srcm      <= '0;
            dstm      <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (req_valid) begin
                    src_sel_q <= req_src_sel;
                    dst_sel_q <= req_dst_sel;
                    vl_q      <= req_vl;
                    phase     <= 1'b0;
                    elem      <= '0;
                    if (req_mode == MODE_INT) begin
                        st <= S_INT_RD;
                    end else if (req_mode == MODE_CR) begin
                        srcm <= '0;
                        dstm <= '0;
                        st   <= (req_vl == '0) ? S_DONE : S_CR_RD;
                    end else begin
                        srcm <= '1;
                        dstm <= '1;
                        st   <= S_DONE;
                    end
                end
                S_INT_RD: if (d_all) begin
                    if (phase) begin
                        dstm <= '1;
                        st   <= S_DONE;
                    end else begin
                        srcm  <= '1;
                        phase <= 1'b1;
                    end
                end else begin
                    st <= S_INT_CAP;
                end
                S_INT_CAP: begin
                    if (phase) begin
                        dstm <= shaped;
                        st   <= S_DONE;
                    end else begin
                        srcm  <= shaped;
                        phase <= 1'b1;
                        st    <= S_INT_RD;
                    end
                end
                S_CR_RD: st <= S_CR_CAP;
                S_CR_CAP: begin
                    if (phase) dstm[elem] <= cr_bit;
                    else       srcm[elem] <= cr_bit;
                    if (last_elem) begin
                        elem <= '0;
                        if (phase) begin
                            st <= S_DONE;
                        end else begin
                            phase <= 1'b1;
                            st    <= S_CR_RD;
                        end
                    end else begin
                        elem <= elem + EL_W'(1);
                        st   <= S_CR_RD;
                    end
                end
                S_DONE: if (mask_ready) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R8: offered masks stay put while the consumer stalls
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && !mask_ready) |=> (mask_valid && $stable(src_mask) && $stable(dst_mask)));

    // R8: never idle and offering at once
    a_r8_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && mask_valid));

    // R3: integer reads only target r3, r10 or r30
    a_r3_int_target: assert property (@(posedge clk) disable iff (!rst_n)
        int_rd_en |-> (int_rd_idx == REG_W'(3) || int_rd_idx == REG_W'(10) ||
                       int_rd_idx == REG_W'(30)));

    // R5: integer reads are separated by the capture cycle
    a_r5_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        int_rd_en |=> !int_rd_en);

    // R7: field walk stays below the vector length
    a_r7_walk_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cr_rd_en |-> (VL_W'(cr_rd_idx) < vl_q));

    // R9: masks only move while a request is in flight
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> ($stable(src_mask) && $stable(dst_mask)));
endmodule

// File: tb/sim_pmask_seq.sv
module sim_pmask_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_mode = '0;
    logic [2:0]  req_src_sel = '0, req_dst_sel = '0;
    logic [6:0]  req_vl = '0;
    logic        int_rd_en;
    logic [4:0]  int_rd_idx;
    logic [63:0] int_rd_data = '0;
    logic        cr_rd_en;
    logic [5:0]  cr_rd_idx;
    logic [3:0]  cr_rd_data = '0;
    logic        mask_valid;
    logic        mask_ready = 1'b0;
    logic [63:0] src_mask, dst_mask;

    logic [63:0] ireg [32];
    logic [3:0]  crf  [64];
    int n_int = 0, n_cr = 0;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmask_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_src_sel(req_src_sel), .req_dst_sel(req_dst_sel),
        .req_vl(req_vl), .int_rd_en(int_rd_en), .int_rd_idx(int_rd_idx),
        .int_rd_data(int_rd_data), .cr_rd_en(cr_rd_en), .cr_rd_idx(cr_rd_idx),
        .cr_rd_data(cr_rd_data), .mask_valid(mask_valid), .mask_ready(mask_ready),
        .src_mask(src_mask), .dst_mask(dst_mask)
    );

    // register-file models: data one clock after enable, reads counted
    always @(posedge clk) begin
        if (int_rd_en) begin
            int_rd_data <= ireg[int_rd_idx];
            n_int++;
        end
        if (cr_rd_en) begin
            cr_rd_data <= crf[cr_rd_idx];
            n_cr++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_int(input logic [2:0] c);
        case (c)
            3'd0: exp_int = '1;
            3'd1: exp_int = 64'd1 << ireg[3][5:0];
            3'd2: exp_int = ireg[3];
            3'd3: exp_int = ~ireg[3];
            3'd4: exp_int = ireg[10];
            3'd5: exp_int = ~ireg[10];
            3'd6: exp_int = ireg[30];
            default: exp_int = ~ireg[30];
        endcase
    endfunction

    function automatic logic [63:0] exp_cr(input logic [2:0] c, input int vl);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++)
            if (i < vl) m[i] = crf[i][c[2:1]] ^ c[0];
        return m;
    endfunction

    task automatic run(input logic [1:0] mode, input logic [2:0] s, input logic [2:0] d,
                       input int vl, input string tag);
        logic [63:0] es, ed, hs, hd;
        int ei, ec, n;
        bit busy_ok;
        if (mode == 2'b01) begin
            es = exp_int(s); ed = exp_int(d);
            ei = int'(s != 3'd0) + int'(d != 3'd0); ec = 0;
        end else if (mode == 2'b10) begin
            es = exp_cr(s, vl); ed = exp_cr(d, vl);
            ei = 0; ec = 2 * vl;
        end else begin
            es = '1; ed = '1; ei = 0; ec = 0;
        end
        @(negedge clk);
        n_int = 0; n_cr = 0;
        req_mode = mode; req_src_sel = s; req_dst_sel = d; req_vl = 7'(vl);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; busy_ok = 1'b1;
        while (!mask_valid && n < 1000) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(mask_valid && busy_ok && !req_ready, {tag, " R8 busy/valid"},
            {62'd0, req_ready, mask_valid}, 64'd1);
        chk(src_mask == es, {tag, " src"}, src_mask, es);
        chk(dst_mask == ed, {tag, " dst"}, dst_mask, ed);
        chk(n_int == ei && n_cr == ec, {tag, " read count"},
            64'(n_int * 1000 + n_cr), 64'(ei * 1000 + ec));
        hs = src_mask; hd = dst_mask;
        repeat (2) @(negedge clk);
        chk(mask_valid && src_mask == hs && dst_mask == hd, "R8 stall hold",
            {63'd0, mask_valid}, 64'd1);
        mask_ready = 1'b1;
        @(negedge clk);
        mask_ready = 1'b0;
        repeat (2) @(negedge clk);
        chk(req_ready && !mask_valid && src_mask == hs && dst_mask == hd, "R9 post hold",
            src_mask ^ hs ^ dst_mask ^ hd, 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) ireg[i] = 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1);
        for (int i = 0; i < 64; i++) crf[i] = 4'(i * 5 + (i >> 3));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready && !mask_valid && src_mask == '0 && dst_mask == '0, "R1 reset",
            src_mask | dst_mask, 64'd0);
        rst_n = 1'b1;
        // R2: no-predicate modes
        run(2'b00, 3'd2, 3'd5, 5, "R2 mode00");
        run(2'b11, 3'd7, 3'd0, 64, "R2 mode11");
        // R3 R4 R5: integer mode, all selector pairs, three register sets
        for (int k = 0; k < 3; k++) begin
            if (k == 1) begin ireg[3] = '1; ireg[10] = 64'h8000_0000_0000_0001; end
            if (k == 2) begin ireg[3] = 64'h0000_0000_0000_0040; ireg[30] = '0; end
            for (int s = 0; s < 8; s++)
                for (int d = 0; d < 8; d++)
                    run(2'b01, 3'(s), 3'(d), 64, (s == 1 || d == 1) ? "R4 unary" : "R3 R5 int");
        end
        // R6 R7: condition walk, all pairs, several lengths, two patterns
        for (int p = 0; p < 2; p++) begin
            if (p == 1) for (int i = 0; i < 64; i++) crf[i] = ~crf[i];
            for (int v = 0; v < 4; v++)
                for (int s = 0; s < 8; s++)
                    for (int d = 0; d < 8; d++)
                        run(2'b10, 3'(s), 3'(d), (v == 0) ? 0 : (v == 1) ? 1 : (v == 2) ? 37 : 64,
                            "R6 R7 cr");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired act=%h exp=%h", 64'd1, 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule